// File: doc/BRIEF.md
# Effective Address Generation Unit

This block is a small clocked unit that computes memory addresses for a processor datapath. A start pulse presents four values: a base value, a 16-bit offset that is sign-extended, the program counter, and a 3-bit mode code. The unit computes one of these results with a single shared adder:

- base plus displacement,
- PC plus displacement,
- the plain base for a post-modify access, which is followed one cycle later by the updated base,
- the sequential next-PC value.

Each effective address goes into a memory address register, which drives the address bus. A one-cycle strobe marks every load of that register.

The post-increment and post-decrement modes take two steps. The first step puts the unmodified base into the address register. The second step reuses the adder to form base plus or minus the access size, and presents that value with a write-back strobe for the register file. While the second step runs, the unit reports busy and ignores any new start. The next-PC mode has its own output and strobe, and leaves the address register alone.

Top module: `eagu_top`

## Requirements
- R1: While reset is high and in the cycle after it is released, mar_out is 0 and addr_valid, base_wb_en, npc_valid and busy are all 0.
- R2: A start with mode 3'b000 loads mar_out with base_in plus the sign-extended offset_in at the next clock edge. addr_valid is high for exactly that one following cycle.
- R3: A start with mode 3'b001 loads mar_out with pc_in plus the sign-extended offset_in at the next clock edge, and addr_valid pulses for one cycle.
- R4: offset_in is sign-extended from bit 15, so 16'hFFF0 adds -16. All address arithmetic wraps modulo 2^32.
- R5: A start with mode 3'b010 (post-increment) loads mar_out with base_in unchanged. In the cycle after addr_valid, base_wb_en is high for one cycle and base_wb_val equals base_in + 4.
- R6: A start with mode 3'b011 (post-decrement) behaves like R5, except that base_wb_val equals base_in - 4, modulo 2^32.
- R7: A start with mode 3'b100 sets next_pc to pc_in + 4 at the next clock edge, with npc_valid high for one cycle. mar_out does not change and addr_valid stays low.
- R8: After an accepted post-modify start, busy is high for exactly one cycle: the cycle in which addr_valid is high. A start in that cycle is ignored: it produces no strobe and does not change mar_out or next_pc.
- R9: A start with a mode code of 3'b101, 3'b110 or 3'b111 is ignored. No strobe rises and mar_out keeps its value.
- R10: Address-type starts in consecutive cycles (modes 000 and 001) are all accepted. Each one yields its own addr_valid cycle, and the results appear in issue order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch an operation using the inputs sampled this cycle |
| mode | input | 3 | Addressing mode code (see R2 to R9) |
| base_in | input | 32 | Base register value |
| offset_in | input | 16 | Signed displacement |
| pc_in | input | 32 | Current program counter |
| mar_out | output | 32 | Memory address register, drives the address bus |
| addr_valid | output | 1 | One-cycle strobe: mar_out was just loaded |
| base_wb_val | output | 32 | Updated base value for post-modify modes |
| base_wb_en | output | 1 | One-cycle write-back strobe for base_wb_val |
| next_pc | output | 32 | Sequential next-PC value |
| npc_valid | output | 1 | One-cycle strobe: next_pc was just updated |
| busy | output | 1 | Post-modify update step in progress; start is ignored |

## Verification
The bench uses the default parameters: a 32-bit address, a 16-bit offset, and an access size and instruction length of 4. With these values the low and high wrap points can be reached with a few vectors: a base near 2^32 plus a positive offset, and a post-decrement from base 0. A negative offset exercises the sign-extension boundary at bit 15. Because the widths are fixed, each expected value can be written as a plain 32-bit sum, and the queued order of strobes shows that back-to-back address starts and the two steps of the post modes are correctly interleaved.

// File: rtl/eagu_pkg.sv
package eagu_pkg;

  typedef enum logic [2:0] {
    MD_BASE_DISP = 3'b000,
    MD_PC_REL    = 3'b001,
    MD_POST_INC  = 3'b010,
    MD_POST_DEC  = 3'b011,
    MD_NEXT_PC   = 3'b100
  } mode_e;

  typedef enum logic {
    PH_ADDR   = 1'b0,
    PH_UPDATE = 1'b1
  } phase_e;

  function automatic logic mode_is_post(input logic [2:0] m);
    return (m == MD_POST_INC) || (m == MD_POST_DEC);
  endfunction

  function automatic logic mode_is_known(input logic [2:0] m);
    return m <= MD_NEXT_PC;
  endfunction

endpackage

// File: rtl/eagu_adder.sv
module eagu_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         sub,
  output logic [W-1:0] sum
);
  logic [W-1:0] opb_eff;

  always_comb begin
    opb_eff = sub ? ~opb : opb;
    sum     = opa + opb_eff + {{(W-1){1'b0}}, sub};
  end
endmodule

// File: rtl/eagu_operand_sel.sv
module eagu_operand_sel
  import eagu_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 16,
  parameter int ACC_SIZE  = 4,
  parameter int INSTR_LEN = 4
) (
  input  logic              upd_phase,
  input  logic [2:0]        mode_now,
  input  logic [2:0]        mode_held,
  input  logic [ADDR_W-1:0] base_now,
  input  logic [ADDR_W-1:0] base_held,
  input  logic [ADDR_W-1:0] pc,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] opa,
  output logic [ADDR_W-1:0] opb,
  output logic              sub
);
  localparam int EXT_W = ADDR_W - OFF_W;
  localparam logic [ADDR_W-1:0] ACC_C = ADDR_W'(ACC_SIZE);
  localparam logic [ADDR_W-1:0] LEN_C = ADDR_W'(INSTR_LEN);

  logic [ADDR_W-1:0] off_sext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign off_sext = {{EXT_W{offset[OFF_W-1]}}, offset};
    end else begin : g_noext
      assign off_sext = offset[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    opa = base_now;
    opb = '0;
    sub = 1'b0;
    if (upd_phase) begin
      opa = base_held;
      opb = ACC_C;
      sub = (mode_held == MD_POST_DEC);
    end else begin
      case (mode_now)
        MD_BASE_DISP: begin opa = base_now; opb = off_sext; end
        MD_PC_REL:    begin opa = pc;       opb = off_sext; end
        MD_POST_INC,
        MD_POST_DEC:  begin opa = base_now; opb = '0;       end
        MD_NEXT_PC:   begin opa = pc;       opb = LEN_C;    end
        default:      begin opa = base_now; opb = '0;       end
      endcase
    end
  end
endmodule

// File: rtl/eagu_ctrl.sv
module eagu_ctrl
  import eagu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] base_in,
  output logic              upd_phase,
  output logic [2:0]        mode_held,
  output logic [ADDR_W-1:0] base_held,
  output logic              ld_mar,
  output logic              ld_npc,
  output logic              ld_wb
);
  phase_e phase_q;
  logic   accept;

  assign accept    = start && (phase_q == PH_ADDR) && mode_is_known(mode);
  assign upd_phase = (phase_q == PH_UPDATE);
  assign ld_mar    = accept && (mode != MD_NEXT_PC);
  assign ld_npc    = accept && (mode == MD_NEXT_PC);
  assign ld_wb     = upd_phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_ADDR;
      mode_held <= '0;
      base_held <= '0;
    end else begin
      if (accept && mode_is_post(mode)) begin
        phase_q   <= PH_UPDATE;
        mode_held <= mode;
        base_held <= base_in;
      end else begin
        phase_q <= PH_ADDR;
      end
    end
  end

  // R8: the update phase lasts a single cycle
  p_update_one_cycle_r8: assert property (@(posedge clk) disable iff (rst)
    upd_phase |=> !upd_phase);
  // R8: an accepted post-mode start always enters the update phase
  p_post_enters_update_r8: assert property (@(posedge clk) disable iff (rst)
    (start && !upd_phase && mode_is_post(mode)) |=> upd_phase);
  // R9: unknown modes never load anything
  p_unknown_mode_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (start && !mode_is_known(mode)) |-> !(ld_mar || ld_npc));
endmodule

// File: rtl/eagu_top.sv
module eagu_top
  import eagu_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int OFF_W     = 16,
  parameter int ACC_SIZE  = 4,
  parameter int INSTR_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] base_in,
  input  logic [OFF_W-1:0]  offset_in,
  input  logic [ADDR_W-1:0] pc_in,
  output logic [ADDR_W-1:0] mar_out,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] base_wb_val,
  output logic              base_wb_en,
  output logic [ADDR_W-1:0] next_pc,
  output logic              npc_valid,
  output logic              busy
);
  logic              upd_phase, ld_mar, ld_npc, ld_wb, sub;
  logic [2:0]        mode_held;
  logic [ADDR_W-1:0] base_held, opa, opb, sum;

  eagu_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .base_in(base_in),
    .upd_phase(upd_phase), .mode_held(mode_held), .base_held(base_held),
    .ld_mar(ld_mar), .ld_npc(ld_npc), .ld_wb(ld_wb)
  );

  eagu_operand_sel #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .ACC_SIZE(ACC_SIZE), .INSTR_LEN(INSTR_LEN)
  ) u_sel (
    .upd_phase(upd_phase), .mode_now(mode), .mode_held(mode_held),
    .base_now(base_in), .base_held(base_held), .pc(pc_in), .offset(offset_in),
    .opa(opa), .opb(opb), .sub(sub)
  );

  eagu_adder #(.W(ADDR_W)) u_add (.opa(opa), .opb(opb), .sub(sub), .sum(sum));

  assign busy = upd_phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      mar_out     <= '0;
      addr_valid  <= 1'b0;
      base_wb_val <= '0;
      base_wb_en  <= 1'b0;
      next_pc     <= '0;
      npc_valid   <= 1'b0;
    end else begin
      addr_valid <= ld_mar;
      base_wb_en <= ld_wb;
      npc_valid  <= ld_npc;
      if (ld_mar) mar_out     <= sum;
      if (ld_wb)  base_wb_val <= sum;
      if (ld_npc) next_pc     <= sum;
    end
  end

  // R2: every address strobe is caused by a start one cycle earlier
  p_addr_from_start_r2: assert property (@(posedge clk) disable iff (rst)
    addr_valid |-> $past(start));
  // R9: the address register only moves when the strobe marks it
  p_mar_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !addr_valid |-> $stable(mar_out));
  // R5: write-back follows the busy cycle
  p_wb_after_busy_r5: assert property (@(posedge clk) disable iff (rst)
    busy |=> (base_wb_en && !busy));
  // R7: next-PC and address strobes never coincide
  p_npc_excl_r7: assert property (@(posedge clk) disable iff (rst)
    npc_valid |-> !addr_valid);
  // R8: a start during busy produces no address strobe
  p_ignore_busy_r8: assert property (@(posedge clk) disable iff (rst)
    busy |=> !addr_valid && !npc_valid);
endmodule

// File: tb/eagu_top_test.sv
module eagu_top_test;
  typedef struct {
    int          kind;   // 0 = MAR, 1 = write-back, 2 = next PC
    logic [31:0] val;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [31:0] base_in = '0;
  logic [15:0] offset_in = '0;
  logic [31:0] pc_in = '0;
  logic [31:0] mar_out, base_wb_val, next_pc;
  logic        addr_valid, base_wb_en, npc_valid, busy;

  int   errors = 0;
  int   checks = 0;
  bit   done = 0;
  exp_t sb[$];

  always #5 clk = ~clk;

  eagu_top uut (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .base_in(base_in),
    .offset_in(offset_in), .pc_in(pc_in), .mar_out(mar_out),
    .addr_valid(addr_valid), .base_wb_val(base_wb_val), .base_wb_en(base_wb_en),
    .next_pc(next_pc), .npc_valid(npc_valid), .busy(busy)
  );

  function automatic logic [31:0] sx(input logic [15:0] o);
    return {{16{o[15]}}, o};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input int k, input logic [31:0] v, input string tag);
    exp_t e;
    e.kind = k; e.val = v; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: pop and compare each strobe as it appears
  task automatic observe(input int k, input logic [31:0] v);
    exp_t e;
    if (sb.size() == 0) begin
      chk(0, "unexpected strobe", v, 32'h0);
    end else begin
      e = sb.pop_front();
      chk(e.kind == k && e.val == v, e.tag, v, e.val);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (addr_valid) observe(0, mar_out);
      if (base_wb_en) observe(1, base_wb_val);
      if (npc_valid)  observe(2, next_pc);
    end
  end

  task automatic drive(input logic [2:0] m, input logic [31:0] b, input logic [15:0] o, input logic [31:0] p);
    start = 1'b1; mode = m; base_in = b; offset_in = o; pc_in = p;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic op(input logic [2:0] m, input logic [31:0] b, input logic [15:0] o,
                    input logic [31:0] p, input string tag);
    case (m)
      3'b000: push(0, b + sx(o), tag);
      3'b001: push(0, p + sx(o), tag);
      3'b010: begin push(0, b, tag); push(1, b + 32'd4, tag); end
      3'b011: begin push(0, b, tag); push(1, b - 32'd4, tag); end
      3'b100: push(2, p + 32'd4, tag);
      default: ;
    endcase
    drive(m, b, o, p);
    if (m == 3'b010 || m == 3'b011) @(negedge clk);
  endtask

  initial begin
    logic [31:0] mar_snap, npc_snap;
    repeat (3) @(negedge clk);
    // R1 reset state during reset
    chk(mar_out == 0 && !addr_valid && !base_wb_en && !npc_valid && !busy,
        "R1 reset", mar_out, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(mar_out == 0 && !addr_valid && !busy, "R1 after release", mar_out, 32'h0);

    op(3'b000, 32'h0000_1000, 16'h0008, 32'h0, "R2 base+8");
    op(3'b000, 32'h0000_2000, 16'hFFF0, 32'h0, "R4 negative offset");
    op(3'b000, 32'hFFFF_FFFC, 16'h0008, 32'h0, "R4 wrap high");
    op(3'b001, 32'h0, 16'h0020, 32'h0000_0400, "R3 pc+0x20");
    op(3'b001, 32'h0, 16'hFFFC, 32'h0000_0400, "R3 pc-4");
    op(3'b010, 32'h0000_8000, 16'h1234, 32'h0, "R5 post-inc");
    op(3'b011, 32'h0000_8000, 16'h1234, 32'h0, "R6 post-dec");
    op(3'b011, 32'h0000_0000, 16'h0000, 32'h0, "R6 post-dec wrap");

    // R7: next PC leaves MAR alone
    mar_snap = mar_out;
    op(3'b100, 32'h0, 16'h0, 32'h0000_0100, "R7 next pc");
    chk(mar_out == mar_snap && !addr_valid, "R7 mar untouched", mar_out, mar_snap);

    // R8: busy cycle, start ignored
    push(0, 32'h0000_5000, "R8 post-inc addr");
    push(1, 32'h0000_5004, "R8 post-inc wb");
    drive(3'b010, 32'h0000_5000, 16'h0, 32'h0);
    chk(busy == 1'b1, "R8 busy high", {31'b0, busy}, 32'h1);
    npc_snap = next_pc;
    drive(3'b100, 32'h0, 16'h0, 32'h0000_9000);
    chk(busy == 1'b0, "R8 busy low after one cycle", {31'b0, busy}, 32'h0);
    @(negedge clk);
    chk(!addr_valid && !npc_valid && next_pc == npc_snap && mar_out == 32'h0000_5000,
        "R8 ignored start", next_pc, npc_snap);

    // R9: unknown mode codes
    for (int m = 5; m < 8; m++) begin
      mar_snap = mar_out;
      drive(3'(m), 32'hDEAD_0000, 16'h0040, 32'h0000_7000);
      @(negedge clk);
      chk(!addr_valid && !npc_valid && !base_wb_en && mar_out == mar_snap,
          "R9 unknown mode ignored", mar_out, mar_snap);
    end

    // R10: back-to-back address starts
    push(0, 32'h0000_0110, "R10 first");
    push(0, 32'h0000_0204, "R10 second");
    push(0, 32'h0000_02F0, "R10 third");
    start = 1'b1; mode = 3'b000; base_in = 32'h100; offset_in = 16'h10; pc_in = 32'h300;
    @(negedge clk);
    mode = 3'b001; offset_in = 16'hFF04; pc_in = 32'h300;
    @(negedge clk);
    mode = 3'b000; base_in = 32'h300; offset_in = 16'hFFF0;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);

    chk(sb.size() == 0, "R10 all expected strobes seen", sb.size(), 32'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule